// File: doc/BRIEF.md
# Indirect SDRAM Controller Register File

This block holds the software-visible configuration and status state of an SDRAM controller. It sits on a simple device-control register bus made of a register number, a read strobe, a write strobe and 32-bit write data. Only two bus register numbers belong to it. One is a pointer port and the other is a window port. Software first writes an internal offset into the pointer port. It then reads or writes the selected internal register through the window port.

Inside the block are two write-one-to-clear error status words, an error address word, a configuration word, a read-only status word, refresh, power-management and ECC configuration words, an ECC error word and one configuration word per bank. Each register applies its own write mask. Status bits react to edges of configuration bits. The ECC interrupt line reports whether the ECC error word holds any set bit. The controller-enable bit and all bank words are exported to the neighbouring command engine.

Top module: `sdram_cfg_regs`

## Requirements
- R1: Bus register 0x010 is the pointer port. A write there stores the full 32-bit value, and a read there returns the last value written. The reset value is zero.
- R2: Read data is registered. It appears on `rd_data` one clock after the cycle with `rd_strobe` high and holds until the next read. A read of any bus register number other than 0x010 or 0x011 returns zero.
- R3: The error status words at offsets 0x00 and 0x08 reset to zero. A window write clears every bit that is 1 in the data and never sets a bit.
- R4: The error address word at offset 0x10 is a plain 32-bit register that reads back what was written. It resets to zero.
- R5: The configuration word at offset 0x20 keeps only data bits 31:21 and resets to 0x00800000. Its bit 31 is driven on `ctrl_enable`.
- R6: The status word at offset 0x24 resets to zero and ignores writes. Bit 31 is cleared when configuration bit 31 rises and set when it falls. Bit 30 is set when configuration bit 30 rises and cleared when it falls.
- R7: The refresh word at offset 0x30 stores data & 0x3FF80000 and resets to 0x05F00000. The ECC configuration word at offset 0x94 stores data & 0x00F00000 and resets to zero.
- R8: The power-management word at offset 0x34 takes bits 31:27 from the data and forces bits 26:22 to ones. All other bits are zero. It resets to 0x07C00000.
- R9: The ECC error word at offset 0x98 stores data & 0xFFF0F000 and resets to zero. `ecc_irq` rises in the same clock as a write that takes the word from zero to nonzero. It falls in the same clock as a write that takes the word from nonzero to zero.
- R10: A window read of the timing offset 0x80 returns 0xFFFFFFFF. So does a window read of any offset not listed in these requirements. A write to an unlisted offset changes no register.
- R11: Bank word i (i = 0..3) sits at offset 0x40 + 4*i and stores data & 0xFFDEE001. It resets to zero, reads back through the window, and is driven on `bank_cfg[32*i+31:32*i]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_num | input | 10 | Device-control register number |
| rd_strobe | input | 1 | Read request for `bus_num` |
| wr_strobe | input | 1 | Write request for `bus_num` |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| ecc_irq | output | 1 | ECC error interrupt |
| ctrl_enable | output | 1 | Configuration enable bit |
| bank_cfg | output | 128 | Packed bank configuration words, bank 0 in the low bits |

## Verification
The status word is the hardest thing to exercise. It can only change as a side effect of edges on two configuration bits, and those bits are themselves reached through the pointer/window pair. The bench therefore walks the configuration word through a sequence of values: both bits rise together, then both fall, then only bit 31 rises. After every step it reads the status word, so each of the four edge rules is seen in isolation. It also writes the status offset directly between steps to show that the word keeps its value.

// File: rtl/sdcfg_pkg.sv
package sdcfg_pkg;
  localparam int DW = 32;

  localparam logic [DW-1:0] OFF_ERR0    = 32'h00;
  localparam logic [DW-1:0] OFF_ERR1    = 32'h08;
  localparam logic [DW-1:0] OFF_ERRADDR = 32'h10;
  localparam logic [DW-1:0] OFF_CFG     = 32'h20;
  localparam logic [DW-1:0] OFF_STAT    = 32'h24;
  localparam logic [DW-1:0] OFF_REFR    = 32'h30;
  localparam logic [DW-1:0] OFF_PWR     = 32'h34;
  localparam logic [DW-1:0] OFF_TIMING  = 32'h80;
  localparam logic [DW-1:0] OFF_ECCCFG  = 32'h94;
  localparam logic [DW-1:0] OFF_ECCERR  = 32'h98;

  localparam logic [DW-1:0] MSK_CFG    = 32'hFFE0_0000;
  localparam logic [DW-1:0] MSK_REFR   = 32'h3FF8_0000;
  localparam logic [DW-1:0] MSK_ECCCFG = 32'h00F0_0000;
  localparam logic [DW-1:0] MSK_ECCERR = 32'hFFF0_F000;
  localparam logic [DW-1:0] MSK_BANK   = 32'hFFDE_E001;
  localparam logic [DW-1:0] MSK_PWR    = 32'hF800_0000;
  localparam logic [DW-1:0] PWR_ONES   = 32'h07C0_0000;

  localparam logic [DW-1:0] RST_CFG  = 32'h0080_0000;
  localparam logic [DW-1:0] RST_REFR = 32'h05F0_0000;
  localparam logic [DW-1:0] RST_PWR  = 32'h07C0_0000;

  localparam int CFG_EN_BIT = 31;
  localparam int CFG_SR_BIT = 30;
endpackage

// File: rtl/sdcfg_bank.sv
module sdcfg_bank
  import sdcfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata & MSK_BANK;
  end

  // R11: a bank write lands masked in the next cycle
  assert_bank_mask_R11: assert property (@(posedge clk) disable iff (rst)
    we |=> (q == ($past(wdata) & MSK_BANK)));
endmodule

// File: rtl/sdcfg_ctrl.sv
module sdcfg_ctrl
  import sdcfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          ecc_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cfg_q,
  output logic [DW-1:0] stat_q,
  output logic [DW-1:0] eccerr_q,
  output logic          irq_q
);
  logic [DW-1:0] cfg_new, ecc_new;
  logic          en_rise, en_fall, sr_rise, sr_fall;

  assign cfg_new = wdata & MSK_CFG;
  assign ecc_new = wdata & MSK_ECCERR;
  assign en_rise = !cfg_q[CFG_EN_BIT] &&  cfg_new[CFG_EN_BIT];
  assign en_fall =  cfg_q[CFG_EN_BIT] && !cfg_new[CFG_EN_BIT];
  assign sr_rise = !cfg_q[CFG_SR_BIT] &&  cfg_new[CFG_SR_BIT];
  assign sr_fall =  cfg_q[CFG_SR_BIT] && !cfg_new[CFG_SR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= RST_CFG;
      stat_q <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_new;
      if (en_rise)      stat_q[CFG_EN_BIT] <= 1'b0;
      else if (en_fall) stat_q[CFG_EN_BIT] <= 1'b1;
      if (sr_rise)      stat_q[CFG_SR_BIT] <= 1'b1;
      else if (sr_fall) stat_q[CFG_SR_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eccerr_q <= '0;
      irq_q    <= 1'b0;
    end else if (ecc_we) begin
      eccerr_q <= ecc_new;
      if (eccerr_q == '0 && ecc_new != '0)      irq_q <= 1'b1;
      else if (eccerr_q != '0 && ecc_new == '0) irq_q <= 1'b0;
    end
  end

  // R6: enabling the controller clears status bit 31
  assert_en_rise_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_q[CFG_EN_BIT] && wdata[CFG_EN_BIT]) |=> !stat_q[CFG_EN_BIT]);
  // R6: disabling it sets status bit 31
  assert_en_fall_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_q[CFG_EN_BIT] && !wdata[CFG_EN_BIT]) |=> stat_q[CFG_EN_BIT]);
  // R9: a zero-to-nonzero write raises the interrupt
  assert_irq_raise_R9: assert property (@(posedge clk) disable iff (rst)
    (ecc_we && eccerr_q == '0 && (wdata & MSK_ECCERR) != '0) |=> irq_q);
  // R9: the interrupt only changes on an ECC error write
  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !ecc_we |=> $stable(irq_q));
endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
  import sdcfg_pkg::*;
#(
  parameter int              BUS_AW      = 10,
  parameter logic [BUS_AW-1:0] PTR_PORT  = 10'h010,
  parameter logic [BUS_AW-1:0] WIN_PORT  = 10'h011,
  parameter int              NUM_BANKS   = 4,
  parameter logic [DW-1:0]   BANK_BASE   = 32'h40,
  parameter int              BANK_STRIDE = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [BUS_AW-1:0]       bus_num,
  input  logic                    rd_strobe,
  input  logic                    wr_strobe,
  input  logic [DW-1:0]           wr_data,
  output logic [DW-1:0]           rd_data,
  output logic                    ecc_irq,
  output logic                    ctrl_enable,
  output logic [NUM_BANKS*DW-1:0] bank_cfg
);
  logic [DW-1:0] ptr_q, err0_q, err1_q, erraddr_q, refr_q, pwr_q, ecccfg_q;
  logic [DW-1:0] cfg_q, stat_q, eccerr_q, rd_sel;
  logic [DW-1:0] bank_q [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_hit;
  logic ptr_wr, win_wr, hit_known;

  assign ptr_wr = wr_strobe && (bus_num == PTR_PORT);
  assign win_wr = wr_strobe && (bus_num == WIN_PORT);

  sdcfg_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .cfg_we(win_wr && ptr_q == OFF_CFG),
    .ecc_we(win_wr && ptr_q == OFF_ECCERR),
    .wdata(wr_data),
    .cfg_q(cfg_q), .stat_q(stat_q), .eccerr_q(eccerr_q), .irq_q(ecc_irq)
  );

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    localparam logic [DW-1:0] OFF_B = BANK_BASE + DW'(i * BANK_STRIDE);
    assign bank_hit[i] = (ptr_q == OFF_B);
    sdcfg_bank u_bank (
      .clk(clk), .rst(rst), .we(win_wr && bank_hit[i]),
      .wdata(wr_data), .q(bank_q[i])
    );
    assign bank_cfg[i*DW +: DW] = bank_q[i];
  end

  assign ctrl_enable = cfg_q[CFG_EN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q     <= '0;
      err0_q    <= '0;
      err1_q    <= '0;
      erraddr_q <= '0;
      refr_q    <= RST_REFR;
      pwr_q     <= RST_PWR;
      ecccfg_q  <= '0;
    end else begin
      if (ptr_wr) ptr_q <= wr_data;
      if (win_wr) begin
        case (ptr_q)
          OFF_ERR0:    err0_q    <= err0_q & ~wr_data;
          OFF_ERR1:    err1_q    <= err1_q & ~wr_data;
          OFF_ERRADDR: erraddr_q <= wr_data;
          OFF_REFR:    refr_q    <= wr_data & MSK_REFR;
          OFF_PWR:     pwr_q     <= (wr_data & MSK_PWR) | PWR_ONES;
          OFF_ECCCFG:  ecccfg_q  <= wr_data & MSK_ECCCFG;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    hit_known = 1'b1;
    case (ptr_q)
      OFF_ERR0:    rd_sel = err0_q;
      OFF_ERR1:    rd_sel = err1_q;
      OFF_ERRADDR: rd_sel = erraddr_q;
      OFF_CFG:     rd_sel = cfg_q;
      OFF_STAT:    rd_sel = stat_q;
      OFF_REFR:    rd_sel = refr_q;
      OFF_PWR:     rd_sel = pwr_q;
      OFF_ECCCFG:  rd_sel = ecccfg_q;
      OFF_ECCERR:  rd_sel = eccerr_q;
      default: begin
        rd_sel    = '1;
        hit_known = 1'b0;
      end
    endcase
    for (int i = 0; i < NUM_BANKS; i++)
      if (!hit_known && bank_hit[i]) rd_sel = bank_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_strobe) begin
      if (bus_num == PTR_PORT)      rd_data <= ptr_q;
      else if (bus_num == WIN_PORT) rd_data <= rd_sel;
      else                          rd_data <= '0;
    end
  end

  // R1: pointer port captures the whole written word
  assert_ptr_store_R1: assert property (@(posedge clk) disable iff (rst)
    ptr_wr |=> (ptr_q == $past(wr_data)));
  // R2: foreign bus numbers read as zero
  assert_foreign_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && bus_num != PTR_PORT && bus_num != WIN_PORT) |=> (rd_data == '0));
  // R2: read data holds without a strobe
  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_strobe |=> $stable(rd_data));
  // R3: a write to error status 0 leaves none of the written ones set
  assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
    (win_wr && ptr_q == OFF_ERR0) |=> ((err0_q & $past(wr_data)) == '0));
  // R6: direct writes to the status word do nothing
  assert_stat_ro_R6: assert property (@(posedge clk) disable iff (rst)
    (win_wr && ptr_q == OFF_STAT) |=> $stable(stat_q));
  // R8: the forced power-management field stays all ones
  assert_pwr_ones_R8: assert property (@(posedge clk) disable iff (rst)
    pwr_q[26:22] == 5'h1F);
endmodule

// File: tb/sim_sdram_cfg_regs.sv
`timescale 1ns/1ps
module sim_sdram_cfg_regs;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [9:0]   bus_num = '0;
  logic         rd_strobe = 1'b0, wr_strobe = 1'b0;
  logic [31:0]  wr_data = '0;
  logic [31:0]  rd_data;
  logic         ecc_irq, ctrl_enable;
  logic [127:0] bank_cfg;
  int errors = 0, checks = 0;

  localparam logic [9:0] PTR = 10'h010, WIN = 10'h011;

  always #2.5 clk = ~clk;

  sdram_cfg_regs u0 (
    .clk(clk), .rst(rst), .bus_num(bus_num), .rd_strobe(rd_strobe),
    .wr_strobe(wr_strobe), .wr_data(wr_data), .rd_data(rd_data),
    .ecc_irq(ecc_irq), .ctrl_enable(ctrl_enable), .bank_cfg(bank_cfg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [9:0] n, input logic [31:0] d);
    @(negedge clk);
    bus_num = n; wr_data = d; wr_strobe = 1'b1;
    @(negedge clk);
    wr_strobe = 1'b0;
  endtask

  task automatic bus_rd(input logic [9:0] n, output logic [31:0] d);
    @(negedge clk);
    bus_num = n; rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    d = rd_data;
  endtask

  task automatic reg_wr(input logic [31:0] off, input logic [31:0] d);
    bus_wr(PTR, off);
    bus_wr(WIN, d);
  endtask

  task automatic reg_rd(input logic [31:0] off, output logic [31:0] d);
    bus_wr(PTR, off);
    bus_rd(WIN, d);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    bus_rd(PTR, v);          chk("R1 pointer reset", v, 32'h0);
    reg_rd(32'h20, v);       chk("R5 config reset", v, 32'h0080_0000);
    chk("R5 ctrl_enable reset", {31'b0, ctrl_enable}, 32'h0);
    reg_rd(32'h24, v);       chk("R6 status reset", v, 32'h0);
    reg_rd(32'h30, v);       chk("R7 refresh reset", v, 32'h05F0_0000);
    reg_rd(32'h34, v);       chk("R8 power reset", v, 32'h07C0_0000);
    reg_rd(32'h98, v);       chk("R9 ecc error reset", v, 32'h0);
    chk("R9 irq reset", {31'b0, ecc_irq}, 32'h0);
    reg_rd(32'h4C, v);       chk("R11 bank3 reset", v, 32'h0);
  endtask

  task automatic t_ports;
    logic [31:0] v;
    bus_wr(PTR, 32'hA5A5_0123);
    bus_rd(PTR, v);          chk("R1 pointer readback", v, 32'hA5A5_0123);
    bus_rd(10'h055, v);      chk("R2 foreign number reads zero", v, 32'h0);
    reg_rd(32'h10, v);
    reg_wr(32'h10, 32'hDEAD_BEEF);
    bus_rd(WIN, v);
    @(negedge clk); @(negedge clk);
    chk("R2 read data holds", rd_data, 32'hDEAD_BEEF);
    chk("R4 error address readback", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_errstat;
    logic [31:0] v;
    reg_wr(32'h00, 32'hFFFF_FFFF);
    reg_rd(32'h00, v);       chk("R3 error status 0 never set", v, 32'h0);
    reg_wr(32'h08, 32'h1234_5678);
    reg_rd(32'h08, v);       chk("R3 error status 1 never set", v, 32'h0);
  endtask

  task automatic t_cfg_status;
    logic [31:0] v;
    reg_wr(32'h20, 32'hFFFF_FFFF);
    reg_rd(32'h20, v);       chk("R5 config mask", v, 32'hFFE0_0000);
    chk("R5 ctrl_enable high", {31'b0, ctrl_enable}, 32'h1);
    reg_rd(32'h24, v);       chk("R6 both bits rise", v, 32'h4000_0000);
    reg_wr(32'h20, 32'h0);
    reg_rd(32'h24, v);       chk("R6 both bits fall", v, 32'h8000_0000);
    chk("R5 ctrl_enable low", {31'b0, ctrl_enable}, 32'h0);
    reg_wr(32'h24, 32'h0);
    reg_rd(32'h24, v);       chk("R6 status ignores writes", v, 32'h8000_0000);
    reg_wr(32'h20, 32'h8000_0000);
    reg_rd(32'h24, v);       chk("R6 enable rise alone", v, 32'h0);
  endtask

  task automatic t_masks;
    logic [31:0] v;
    reg_wr(32'h30, 32'hFFFF_FFFF);
    reg_rd(32'h30, v);       chk("R7 refresh mask", v, 32'h3FF8_0000);
    reg_wr(32'h94, 32'hFFFF_FFFF);
    reg_rd(32'h94, v);       chk("R7 ecc config mask", v, 32'h00F0_0000);
    reg_wr(32'h34, 32'h0);
    reg_rd(32'h34, v);       chk("R8 power forced ones", v, 32'h07C0_0000);
    reg_wr(32'h34, 32'hFFFF_FFFF);
    reg_rd(32'h34, v);       chk("R8 power all ones", v, 32'hFFC0_0000);
  endtask

  task automatic t_ecc;
    logic [31:0] v;
    reg_wr(32'h98, 32'h0000_0FFF);
    chk("R9 masked-out write keeps irq low", {31'b0, ecc_irq}, 32'h0);
    reg_wr(32'h98, 32'h1234_5678);
    chk("R9 irq raised", {31'b0, ecc_irq}, 32'h1);
    reg_rd(32'h98, v);       chk("R9 ecc error mask", v, 32'h1230_5000);
    reg_wr(32'h98, 32'h0000_1000);
    chk("R9 irq stays on nonzero", {31'b0, ecc_irq}, 32'h1);
    reg_wr(32'h98, 32'h000F_0FFF);
    chk("R9 irq lowered", {31'b0, ecc_irq}, 32'h0);
  endtask

  task automatic t_unknown;
    logic [31:0] v;
    reg_rd(32'h80, v);       chk("R10 timing reads ones", v, 32'hFFFF_FFFF);
    reg_wr(32'h50, 32'h0);
    reg_rd(32'h50, v);       chk("R10 unknown reads ones", v, 32'hFFFF_FFFF);
    reg_rd(32'h30, v);       chk("R10 unknown write ignored", v, 32'h3FF8_0000);
    chk("R10 unknown write leaves banks", bank_cfg[31:0] | bank_cfg[63:32], 32'h0);
  endtask

  task automatic t_banks;
    logic [31:0] v;
    reg_wr(32'h48, 32'hFFFF_FFFF);
    reg_rd(32'h48, v);       chk("R11 bank2 mask", v, 32'hFFDE_E001);
    chk("R11 bank2 export", bank_cfg[95:64], 32'hFFDE_E001);
    reg_wr(32'h44, 32'h1234_5679);
    chk("R11 bank1 export", bank_cfg[63:32], 32'h1214_4001);
    chk("R11 bank0 untouched", bank_cfg[31:0], 32'h0);
    chk("R11 bank3 untouched", bank_cfg[127:96], 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ports();
    t_errstat();
    t_cfg_status();
    t_masks();
    t_ecc();
    t_unknown();
    t_banks();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule